// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block loads a preset pattern into every word of a switch connection memory. The memory holds 32 streams of 256 channels each, one 16-bit word per location. It is addressed by a 13-bit index: the stream number in the upper five bits and the channel number in the lower eight. Host bus decoding happens upstream and selects memory space before a request reaches this block.

A 16-bit control word holds an arm bit, a start bit and a 3-bit fill pattern in bits 15:13. To begin a sweep, the host sets arm and start in the same write. The block then walks the whole memory one word per clock, from index 0 upward. Each word receives the pattern in its top three bits and zeros in bits 12:0. When the sweep ends, the block clears the start bit itself. Clearing arm in the middle of a sweep stops the sweep. While the sweep runs, it owns the memory write port and host writes are held off.

Top module: `cmf_top`

## Requirements
- R1: After reset the control word reads 0, `busy` is low, `mem_we` is low and `host_ready` is high.
- R2: The control word has arm at bit 0, start at bit 1 and the pattern at bits 15:13, and it reads back through `ctl_rdata`. A write that sets start with arm at 0 stores start as 0 and starts no sweep.
- R3: A sweep starts on the clock after the control word holds arm and start together. `busy` then rises, and the sweep writes indices 0 to 8191 in ascending order, one per clock. Each index is {stream[4:0], channel[7:0]}.
- R4: Every sweep word is {pattern, 13'b0}. The pattern is the one held when the sweep started; a later change to the control pattern does not alter the running sweep.
- R5: A full sweep keeps `busy` high for exactly 8192 clocks, which is no more than two frame periods. The edge that writes the last word also clears start and drops `busy`, and it leaves arm and the pattern unchanged.
- R6: While `busy` is high, `host_ready` is low and host writes stall. When idle, a host request passes to the memory port in the same cycle.
- R7: If arm is cleared during a sweep, no sweep write occurs from the next cycle on. `busy` falls one clock later and start reads 0.
- R8: When a host control write lands on the completion edge, the hardware clear of start wins. The other fields of that write take effect, and no new sweep begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback |
| host_req | input | 1 | Host memory write request |
| host_addr | input | 13 | Host write index {stream, channel} |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host write accepted this cycle when high |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory write index |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Sweep in progress |

## Verification
Two events can fall in the same cycle, and the bench provokes both. In the first, the host writes the control word with start set on exactly the clock that writes index 8191. The bench judges that start reads back 0 while the new pattern is kept, and that `busy` stays low afterwards. In the second, a host memory write is left pending across the end of a sweep. Its scoreboard entry is queued behind the 8192 sweep words, so it must appear at the memory port on the first clock after the last word and not before.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int STREAMS_DEF  = 32;
  localparam int CHANNELS_DEF = 256;
  localparam int WORD_W_DEF   = 16;
  localparam int PAT_W_DEF    = 3;
  localparam int FRAME_DEF    = 8192;  // clocks per frame period

  // control word bit positions
  localparam int ARM_BIT   = 0;
  localparam int START_BIT = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cmf_ctl_reg.sv
module cmf_ctl_reg
  import cmf_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int PAT_W  = PAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              hw_clr_start,
  output logic              arm,
  output logic              start,
  output logic [PAT_W-1:0]  pattern,
  output logic [WORD_W-1:0] ctl_rdata
);
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic              ctl_en;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d            = ctl_wdata;
      ctl_d[START_BIT] = ctl_wdata[START_BIT] & ctl_wdata[ARM_BIT];
    end
    if (hw_clr_start) ctl_d[START_BIT] = 1'b0;  // hardware clear wins (R8)
  end

  assign ctl_en = ctl_wr | hw_clr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign arm       = ctl_q[ARM_BIT];
  assign start     = ctl_q[START_BIT];
  assign pattern   = ctl_q[WORD_W-1 -: PAT_W];
  assign ctl_rdata = ctl_q;

  // R2: a stored start bit always has arm beside it
  assert_start_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> arm);
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
  import cmf_pkg::*;
#(
  parameter int DEPTH  = STREAMS_DEF * CHANNELS_DEF,
  parameter int PAT_W  = PAT_W_DEF,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              start,
  input  logic [PAT_W-1:0]  pattern,
  output logic              run,
  output logic              seq_we,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [PAT_W-1:0]  seq_pat,
  output logic              finish
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [PAT_W-1:0]  pat_q, pat_d;
  logic              go, last, cnt_en;

  assign go     = (state_q == SEQ_IDLE) & arm & start;
  assign last   = (cnt_q == ADDR_W'(DEPTH - 1));
  assign run    = (state_q == SEQ_RUN);
  assign finish = run & (~arm | last);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pat_d   = pat_q;
    unique case (state_q)
      SEQ_IDLE: if (go) begin
        state_d = SEQ_RUN;
        cnt_d   = '0;
        pat_d   = pattern;  // captured once (R4)
      end
      SEQ_RUN: begin
        if (finish) state_d = SEQ_IDLE;
        else        cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign cnt_en = go | run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pat_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pat_q   <= pat_d;
    end
  end

  assign seq_we   = run & arm;
  assign seq_addr = cnt_q;
  assign seq_pat  = pat_q;

  // R4: sweep pattern is frozen while running
  assert_pat_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(seq_pat));
  // R7: a cleared arm ends the sweep on the next edge
  assert_abort_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !arm) |=> !run);
endmodule

// File: rtl/cmf_port_arb.sv
module cmf_port_arb #(
  parameter int ADDR_W = 13,
  parameter int WORD_W = 16,
  parameter int PAT_W  = 3,
  localparam int LOW_W = WORD_W - PAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_run,
  input  logic              seq_we,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [PAT_W-1:0]  seq_pat,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  always_comb begin
    host_ready = ~seq_run;
    if (seq_run) begin
      mem_we    = seq_we;
      mem_addr  = seq_addr;
      mem_wdata = {seq_pat, {LOW_W{1'b0}}};
    end else begin
      mem_we    = host_req;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end
  end

  // R6: no host write reaches memory during a sweep
  assert_host_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_run |-> !host_ready);
  // R4: sweep words carry zeros below the pattern
  assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_run && mem_we) |-> (mem_wdata[LOW_W-1:0] == '0));
endmodule

// File: rtl/cmf_top.sv
module cmf_top
  import cmf_pkg::*;
#(
  parameter int STREAMS      = STREAMS_DEF,
  parameter int CHANNELS     = CHANNELS_DEF,
  parameter int WORD_W       = WORD_W_DEF,
  parameter int PAT_W        = PAT_W_DEF,
  parameter int FRAME_CYCLES = FRAME_DEF,
  localparam int DEPTH  = STREAMS * CHANNELS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WIN_W  = $clog2(2 * FRAME_CYCLES) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [WORD_W-1:0] ctl_rdata,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic             arm, start, run, seq_we, finish;
  logic [PAT_W-1:0] pattern, seq_pat;
  logic [ADDR_W-1:0] seq_addr;

  cmf_ctl_reg #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .hw_clr_start(finish), .arm(arm), .start(start), .pattern(pattern),
    .ctl_rdata(ctl_rdata)
  );

  cmf_seq #(.DEPTH(DEPTH), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .arm(arm), .start(start), .pattern(pattern),
    .run(run), .seq_we(seq_we), .seq_addr(seq_addr), .seq_pat(seq_pat),
    .finish(finish)
  );

  cmf_port_arb #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .seq_run(run), .seq_we(seq_we),
    .seq_addr(seq_addr), .seq_pat(seq_pat), .host_req(host_req),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign busy = run;

  // sweep-length window counter for the two-frame bound
  logic [WIN_W-1:0] win_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) win_q <= '0;
    else if (busy)   win_q <= win_q + 1'b1;
    else             win_q <= '0;
  end

  assert_two_frames_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> (win_q < WIN_W'(2 * FRAME_CYCLES)));
  assert_first_index_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> (mem_addr == '0));
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy) && mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));
  assert_start_cleared_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> !ctl_rdata[START_BIT]);
  assert_no_write_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !ctl_rdata[ARM_BIT]) |-> !mem_we);
endmodule

// File: tb/cmf_top_tb.sv
module cmf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        host_req = 1'b0;
  logic [12:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, mem_we, busy;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmf_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .host_req(host_req), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  typedef struct {
    logic [12:0] a;
    logic [15:0] d;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    busy_cycles = 0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: sample a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (busy) busy_cycles++;
        if (mem_we) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected write", {3'b0, mem_addr, mem_wdata}, 32'h0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check((mem_addr == it.a) && (mem_wdata == it.d), it.tag,
                  {3'b0, mem_addr, mem_wdata}, {3'b0, it.a, it.d});
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  task automatic push_sweep(input logic [2:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.a = 13'(i);
      it.d = {pat, 13'h0};
      it.tag = "R3/R4 sweep word";
      exp_q.push_back(it);
    end
  endtask

  task automatic ctl_write(input logic [15:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic host_write(input logic [12:0] a, input logic [15:0] d);
    item_t it;
    it.a = a; it.d = d; it.tag = "R6 host write";
    exp_q.push_back(it);
    @(negedge clk);
    host_req = 1'b1; host_addr = a; host_wdata = d;
    forever begin
      #(CLK_PERIOD/4);
      if (host_ready) break;
      if (busy) check(!host_ready, "R6 stall while busy", {31'b0, host_ready}, 32'h0);
      @(negedge clk);
    end
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    // R1 reset state
    check(ctl_rdata == 16'h0, "R1 ctl word", {16'h0, ctl_rdata}, 32'h0);
    check(!busy, "R1 busy", {31'b0, busy}, 32'h0);
    check(!mem_we, "R1 mem_we", {31'b0, mem_we}, 32'h0);
    check(host_ready, "R1 host_ready", {31'b0, host_ready}, 32'h1);

    // R2 start without arm is dropped
    ctl_write(16'hA002);
    repeat (3) settle();
    check(ctl_rdata == 16'hA000, "R2 start needs arm", {16'h0, ctl_rdata}, 32'hA000);
    check(!busy, "R2 no sweep", {31'b0, busy}, 32'h0);

    // R6 idle host write passes through
    host_write(13'h0123, 16'hBEEF);

    // full sweep, pattern 3; mid-sweep pattern change (R4); pending host write (R6)
    push_sweep(3'd3, NWORDS);
    busy_cycles = 0;
    ctl_write(16'h6003);
    settle();
    check(busy, "R3 busy rises", {31'b0, busy}, 32'h1);
    repeat (100) @(negedge clk);
    ctl_write(16'hE003);
    host_write(13'h0456, 16'h1234);
    settle();
    check(!busy, "R5 busy low after sweep", {31'b0, busy}, 32'h0);
    check(ctl_rdata == 16'hE001, "R5 start self-cleared", {16'h0, ctl_rdata}, 32'hE001);
    check(busy_cycles == NWORDS, "R5 sweep length", 32'(busy_cycles), 32'(NWORDS));
    repeat (20) settle();
    check(!busy, "R8 no restart", {31'b0, busy}, 32'h0);
    check(exp_q.size() == 0, "R3 all words seen", 32'(exp_q.size()), 32'h0);

    // R7 abort after 49 writes
    push_sweep(3'd2, 49);
    ctl_write(16'h4003);
    repeat (48) @(negedge clk);
    ctl_write(16'h4000);
    repeat (3) settle();
    check(!busy, "R7 busy low after abort", {31'b0, busy}, 32'h0);
    check(ctl_rdata == 16'h4000, "R7 start cleared", {16'h0, ctl_rdata}, 32'h4000);
    check(exp_q.size() == 0, "R7 write count", 32'(exp_q.size()), 32'h0);

    // R8 control write on the completion edge
    push_sweep(3'd1, NWORDS);
    busy_cycles = 0;
    ctl_write(16'h2003);
    repeat (8191) @(negedge clk);
    ctl_write(16'hC003);
    repeat (2) settle();
    check(ctl_rdata == 16'hC001, "R8 hw clear wins", {16'h0, ctl_rdata}, 32'hC001);
    check(busy_cycles == NWORDS, "R5 second sweep length", 32'(busy_cycles), 32'(NWORDS));
    repeat (10) settle();
    check(!busy, "R8 no new sweep", {31'b0, busy}, 32'h0);
    check(exp_q.size() == 0, "R8 queue drained", 32'(exp_q.size()), 32'h0);

    host_write(13'h1FFF, 16'h5A5A);
    repeat (3) settle();
    check(exp_q.size() == 0, "R6 final host write", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule